// File: doc/BRIEF.md
# High-Speed Reset Chirp Sequencer

This block is the device-side sequencer that takes a full-speed attached peripheral through the start of the high-speed negotiation. It sits between the receive-command decoder and a ULPI link layer that performs register writes and transmit commands. The sequencer tracks the line state reported in receive commands. It waits until the host has held the bus in SE0 long enough to count as a bus reset.

Once a reset is qualified, the sequencer asks the link to write the chirp setting into the PHY's function-control register. It then asks for a no-PID transmit command, which makes the PHY drive chirp K, and keeps supplying zero bytes for a programmed number of cycles. It ends the transmit with a one-cycle stop strobe. After that it watches the receive commands for the host's alternating K/J chirps. It reports either that high-speed mode was reached or that it has fallen back to full speed.

All requests to the link use a request/acknowledge handshake. A request is never presented while the PHY owns the data bus. A request that the link aborts is presented again.

Top module: `hs_chirp_seq`

## Requirements
- R1: After a synchronous active-low reset, `reg_req`, `tx_req`, `tx_stop`, `hs_mode` and `fs_fallback` are all low.
- R2: The line state is latched from `rx_linestate` on each cycle with `rx_valid` high. Line state 2'b00 is SE0, 2'b01 is J and 2'b10 is K. A bus reset is recognised only after the latched line state has been SE0 for `SE0_CYCLES` (default 150) consecutive cycles. `reg_req` then rises no later than two cycles after that.
- R3: If the latched line state leaves SE0 before the count completes, the SE0 count restarts from zero when SE0 returns.
- R4: The register write request carries address 0x04 and data 0x54. It stays asserted until `reg_ack` is seen.
- R5: Neither `reg_req` nor `tx_req` is high in any cycle in which `dir` is high.
- R6: If `reg_abort` or `tx_abort` is seen with the matching request, that request drops for exactly one cycle and is then presented again.
- R7: After the register write is acknowledged, `tx_req` is raised with `tx_byte` = 0x40. The transmit acknowledge is sampled at a clock edge. For the next `CHIRP_CYCLES` edges `tx_byte` is 0x00 and `tx_req` is low. `tx_stop` is then high for exactly one cycle, `CHIRP_CYCLES` edges after that acknowledge edge.
- R8: After the stop strobe, a K receive command followed by a J receive command counts as one host chirp pair. After `KJ_PAIRS` (default 3) pairs, `hs_mode` rises within two cycles of the last J and then stays high.
- R9: If the pairs are not complete within `DETECT_TIMEOUT` cycles after the stop strobe, `fs_fallback` rises and stays high. `hs_mode` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir | input | 1 | High while the PHY owns the data bus |
| rx_valid | input | 1 | A receive command is present this cycle |
| rx_linestate | input | 2 | Line state field of the receive command |
| reg_req | output | 1 | Register write request to the link |
| reg_addr | output | 8 | Register address of the write |
| reg_data | output | 8 | Register data of the write |
| reg_ack | input | 1 | Link completed the register write |
| reg_abort | input | 1 | Link aborted the register write |
| tx_req | output | 1 | Transmit command request to the link |
| tx_byte | output | 8 | Transmit command byte, then chirp data bytes |
| tx_ack | input | 1 | Link accepted the transmit command |
| tx_abort | input | 1 | Link aborted the transmit command |
| tx_stop | output | 1 | One-cycle end-of-transmit strobe |
| hs_mode | output | 1 | High-speed handshake completed |
| fs_fallback | output | 1 | Handshake timed out, full speed kept |

## Verification
The bench keeps `SE0_CYCLES` at 150 and `KJ_PAIRS` at 3. This means the SE0 qualification window and the pair count are exercised at their real values. It shortens `CHIRP_CYCLES` to 40 and `DETECT_TIMEOUT` to 200. With those values the exact stop-strobe cycle and the full-speed fallback path can both be reached in a few hundred cycles, next to a complete high-speed run.

// File: rtl/chirp_pkg.sv
`timescale 1ns/1ps
// Shared constants and the sequencer state type.
// Assumes the ULPI line state encoding: 00 SE0, 01 J, 10 K.
package chirp_pkg;
    localparam logic [1:0] LS_SE0 = 2'b00;
    localparam logic [1:0] LS_J   = 2'b01;
    localparam logic [1:0] LS_K   = 2'b10;

    localparam logic [7:0] FUNC_REG_ADDR = 8'h04;
    localparam logic [7:0] FUNC_HS_CHIRP = 8'h54;
    localparam logic [7:0] TX_NOPID_CMD  = 8'h40;
    localparam logic [7:0] CHIRP_BYTE    = 8'h00;

    typedef enum logic [2:0] {
        ST_FS_WATCH,
        ST_WR_FUNC,
        ST_TX_CMD,
        ST_CHIRP,
        ST_STOP,
        ST_DETECT,
        ST_HS,
        ST_FS_FALLBACK
    } seq_state_t;
endpackage

// File: rtl/se0_qualifier.sv
`timescale 1ns/1ps
// Latches the line state from receive commands and counts consecutive
// cycles of SE0. Raises 'qualified' once SE0 has lasted SE0_CYCLES.
// Assumes the counter is only needed while 'en' is high; it clears otherwise.
module se0_qualifier
    import chirp_pkg::*;
#(
    parameter int SE0_CYCLES = 150
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       rx_valid,
    input  logic [1:0] rx_ls,
    output logic       qualified
);
    localparam int CW = $clog2(SE0_CYCLES + 1);

    logic [1:0]    ls_q;
    logic [CW-1:0] cnt;

    // Hold the most recent line state reported by the PHY.
    always_ff @(posedge clk) begin
        if (!rst_n)        ls_q <= LS_J;
        else if (rx_valid) ls_q <= rx_ls;
    end

    // Count SE0 cycles; any other line state restarts the count.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)              cnt <= '0;
        else if (ls_q != LS_SE0)        cnt <= '0;
        else if (cnt != CW'(SE0_CYCLES)) cnt <= cnt + CW'(1);
    end

    assign qualified = en && (cnt == CW'(SE0_CYCLES));

    AST_QUAL_FOLLOWS_SE0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qualified) |-> $past(ls_q == LS_SE0)); // R2
endmodule

// File: rtl/link_req_port.sv
`timescale 1ns/1ps
// Request/acknowledge port toward the link layer. Presents a request while
// the sequencer wants it and the PHY does not own the bus; after an abort
// it backs off for one cycle and presents the request again.
// Assumes 'want' stays high until 'done' has been seen.
module link_req_port (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic dir,
    input  logic ack,
    input  logic abort,
    output logic req,
    output logic done
);
    logic backoff;

    // One idle cycle after an aborted request.
    always_ff @(posedge clk) begin
        if (!rst_n) backoff <= 1'b0;
        else        backoff <= req && abort;
    end

    assign req  = want && !dir && !backoff;
    assign done = req && ack && !abort;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && !abort) |=> (req || dir)); // R4
    AST_RETRY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req && abort) |=> !req); // R6
endmodule

// File: rtl/kj_detect.sv
`timescale 1ns/1ps
// Counts host chirp pairs (a K followed by a J) from receive commands and
// runs a timeout window. Both clear while 'en' is low.
// Assumes other line states between chirps are noise and are ignored.
module kj_detect
    import chirp_pkg::*;
#(
    parameter int KJ_PAIRS       = 3,
    parameter int DETECT_TIMEOUT = 150000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       rx_valid,
    input  logic [1:0] rx_ls,
    output logic       found,
    output logic       expired
);
    localparam int PW = $clog2(KJ_PAIRS + 1);
    localparam int TW = $clog2(DETECT_TIMEOUT + 1);

    logic [PW-1:0] pairs;
    logic          want_j;
    logic [TW-1:0] tmr;

    // Track the K-then-J alternation and count complete pairs.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pairs  <= '0;
            want_j <= 1'b0;
        end else if (rx_valid && pairs != PW'(KJ_PAIRS)) begin
            if (rx_ls == LS_K) begin
                want_j <= 1'b1;
            end else if (rx_ls == LS_J && want_j) begin
                pairs  <= pairs + PW'(1);
                want_j <= 1'b0;
            end
        end
    end

    // Window timer for the whole detection phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)                  tmr <= '0;
        else if (tmr != TW'(DETECT_TIMEOUT)) tmr <= tmr + TW'(1);
    end

    assign found   = en && (pairs == PW'(KJ_PAIRS));
    assign expired = en && (tmr == TW'(DETECT_TIMEOUT)) && !found;

    AST_PAIR_ON_RXCMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(found) |-> $past(rx_valid)); // R8
endmodule

// File: rtl/hs_chirp_seq.sv
`timescale 1ns/1ps
// Device-side high-speed reset chirp sequencer. Qualifies a bus reset,
// writes the chirp setting to the PHY's function-control register, sends
// chirp K through a no-PID transmit, ends it with a stop strobe and then
// waits for the host chirp pairs or times out to full speed.
// Assumes the link layer performs the actual ULPI bus cycles.
module hs_chirp_seq
    import chirp_pkg::*;
#(
    parameter int SE0_CYCLES     = 150,
    parameter int CHIRP_CYCLES   = 60000,
    parameter int KJ_PAIRS       = 3,
    parameter int DETECT_TIMEOUT = 150000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dir,
    input  logic       rx_valid,
    input  logic [1:0] rx_linestate,
    output logic       reg_req,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_data,
    input  logic       reg_ack,
    input  logic       reg_abort,
    output logic       tx_req,
    output logic [7:0] tx_byte,
    input  logic       tx_ack,
    input  logic       tx_abort,
    output logic       tx_stop,
    output logic       hs_mode,
    output logic       fs_fallback
);
    localparam int CCW = $clog2(CHIRP_CYCLES + 1);

    seq_state_t     state;
    logic [CCW-1:0] chirp_cnt;
    logic           se0_qual;
    logic           reg_done;
    logic           tx_done;
    logic           pairs_found;
    logic           detect_expired;

    se0_qualifier #(.SE0_CYCLES(SE0_CYCLES)) i_se0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (state == ST_FS_WATCH),
        .rx_valid  (rx_valid),
        .rx_ls     (rx_linestate),
        .qualified (se0_qual)
    );

    link_req_port i_reg_port (
        .clk   (clk),
        .rst_n (rst_n),
        .want  (state == ST_WR_FUNC),
        .dir   (dir),
        .ack   (reg_ack),
        .abort (reg_abort),
        .req   (reg_req),
        .done  (reg_done)
    );

    link_req_port i_tx_port (
        .clk   (clk),
        .rst_n (rst_n),
        .want  (state == ST_TX_CMD),
        .dir   (dir),
        .ack   (tx_ack),
        .abort (tx_abort),
        .req   (tx_req),
        .done  (tx_done)
    );

    kj_detect #(.KJ_PAIRS(KJ_PAIRS), .DETECT_TIMEOUT(DETECT_TIMEOUT)) i_kj (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (state == ST_DETECT),
        .rx_valid (rx_valid),
        .rx_ls    (rx_linestate),
        .found    (pairs_found),
        .expired  (detect_expired)
    );

    // Sequencer state transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FS_WATCH;
        end else begin
            case (state)
                ST_FS_WATCH: if (se0_qual) state <= ST_WR_FUNC;
                ST_WR_FUNC:  if (reg_done) state <= ST_TX_CMD;
                ST_TX_CMD:   if (tx_done)  state <= ST_CHIRP;
                ST_CHIRP:    if (chirp_cnt == CCW'(CHIRP_CYCLES - 1)) state <= ST_STOP;
                ST_STOP:     state <= ST_DETECT;
                ST_DETECT: begin
                    if (pairs_found)         state <= ST_HS;
                    else if (detect_expired) state <= ST_FS_FALLBACK;
                end
                default:     state <= state;
            endcase
        end
    end

    // Length of the chirp K, counted in link clock cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_CHIRP) chirp_cnt <= '0;
        else                             chirp_cnt <= chirp_cnt + CCW'(1);
    end

    assign reg_addr    = FUNC_REG_ADDR;
    assign reg_data    = FUNC_HS_CHIRP;
    assign tx_byte     = (state == ST_TX_CMD) ? TX_NOPID_CMD : CHIRP_BYTE;
    assign tx_stop     = (state == ST_STOP);
    assign hs_mode     = (state == ST_HS);
    assign fs_fallback = (state == ST_FS_FALLBACK);

    AST_NO_REQ_WHILE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req || tx_req) |-> !dir); // R5
    AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stop |=> !tx_stop); // R7
    AST_HS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        hs_mode |=> hs_mode); // R8
    AST_FALLBACK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fs_fallback |=> (fs_fallback && !hs_mode)); // R9
endmodule

// File: tb/test_hs_chirp_seq.sv
`timescale 1ns/1ps
module test_hs_chirp_seq;
    localparam int SE0_N   = 150;
    localparam int CHIRP_N = 40;
    localparam int PAIRS_N = 3;
    localparam int TMO_N   = 200;

    logic       clk = 1'b0;
    logic       rst_n, dir, rx_valid, reg_ack, reg_abort, tx_ack, tx_abort;
    logic [1:0] rx_linestate;
    logic       reg_req, tx_req, tx_stop, hs_mode, fs_fallback;
    logic [7:0] reg_addr, reg_data, tx_byte;
    int         n_chk = 0;
    int         n_bad = 0;

    always #2.5 clk = ~clk;

    hs_chirp_seq #(.SE0_CYCLES(SE0_N), .CHIRP_CYCLES(CHIRP_N),
                   .KJ_PAIRS(PAIRS_N), .DETECT_TIMEOUT(TMO_N)) i_hs_chirp_seq (
        .clk(clk), .rst_n(rst_n), .dir(dir), .rx_valid(rx_valid),
        .rx_linestate(rx_linestate), .reg_req(reg_req), .reg_addr(reg_addr),
        .reg_data(reg_data), .reg_ack(reg_ack), .reg_abort(reg_abort),
        .tx_req(tx_req), .tx_byte(tx_byte), .tx_ack(tx_ack), .tx_abort(tx_abort),
        .tx_stop(tx_stop), .hs_mode(hs_mode), .fs_fallback(fs_fallback));

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic rx_cmd(input logic [1:0] ls);
        rx_valid = 1'b1;
        rx_linestate = ls;
        tick();
        rx_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        dir = 1'b0; rx_valid = 1'b0; rx_linestate = 2'b01;
        reg_ack = 1'b0; reg_abort = 1'b0; tx_ack = 1'b0; tx_abort = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    // R1: every output idle after reset
    task automatic t_reset_state();
        do_reset();
        check(!reg_req && !tx_req && !tx_stop && !hs_mode && !fs_fallback, "R1 outputs idle",
              {reg_req, tx_req, tx_stop, hs_mode, fs_fallback}, 0);
    endtask

    // R3 then R2: broken SE0 restarts the count; unbroken SE0 qualifies on time
    task automatic t_se0_qualify();
        bit early = 0;
        int n = 0;
        rx_cmd(2'b00);
        for (int i = 0; i < 139; i++) begin tick(); if (reg_req) early = 1; end
        rx_cmd(2'b01);
        repeat (3) tick();
        rx_cmd(2'b00);
        for (int i = 0; i < 140; i++) begin if (reg_req) early = 1; tick(); n++; end
        check(!early, "R3 no reset after broken SE0", early, 0);
        while (!reg_req && n < 400) begin tick(); n++; end
        check(n >= SE0_N + 1 && n <= SE0_N + 2, "R2 request latency", n, SE0_N + 1);
    endtask

    // R4, R5, R6, R7: register write handshake then transmit command
    task automatic t_reg_write();
        repeat (3) tick();
        check(reg_req && reg_addr == 8'h04 && reg_data == 8'h54, "R4 held write fields",
              {reg_req, reg_addr, reg_data}, {1'b1, 8'h04, 8'h54});
        reg_abort = 1'b1; tick(); reg_abort = 1'b0;
        check(!reg_req, "R6 drop after abort", reg_req, 0);
        tick();
        check(reg_req, "R6 retry after abort", reg_req, 1);
        dir = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            check(!reg_req, "R5 no request while dir high", reg_req, 0);
        end
        dir = 1'b0; #1;
        check(reg_req, "R5 request after dir low", reg_req, 1);
        reg_ack = 1'b1; tick(); reg_ack = 1'b0;
        check(!reg_req && tx_req && tx_byte == 8'h40, "R7 nopid command",
              {reg_req, tx_req, tx_byte}, {1'b0, 1'b1, 8'h40});
        tx_abort = 1'b1; tick(); tx_abort = 1'b0;
        check(!tx_req, "R6 tx drop after abort", tx_req, 0);
        tick();
        check(tx_req && tx_byte == 8'h40, "R6 tx retry", {tx_req, tx_byte}, {1'b1, 8'h40});
    endtask

    // R7: chirp length and stop strobe
    task automatic t_chirp();
        int n = 0;
        bit bad_byte = 0;
        tx_ack = 1'b1; tick(); tx_ack = 1'b0;
        while (!tx_stop && n < 1000) begin
            if (tx_byte != 8'h00 || tx_req) bad_byte = 1;
            tick(); n++;
        end
        check(!bad_byte, "R7 zero bytes during chirp", bad_byte, 0);
        check(n == CHIRP_N, "R7 stop strobe cycle", n, CHIRP_N);
        tick();
        check(!tx_stop, "R7 stop one cycle", tx_stop, 0);
    endtask

    // R8: three K/J pairs give high speed
    task automatic t_detect_hs();
        rx_cmd(2'b10); rx_cmd(2'b01); tick();
        rx_cmd(2'b01); rx_cmd(2'b10); rx_cmd(2'b00); rx_cmd(2'b01);
        repeat (3) tick();
        check(!hs_mode, "R8 not after two pairs", hs_mode, 0);
        rx_cmd(2'b10); rx_cmd(2'b01);
        tick();
        check(hs_mode && !fs_fallback, "R8 hs after third pair", {hs_mode, fs_fallback}, 2);
        repeat (300) tick();
        check(hs_mode && !fs_fallback, "R8 hs sticky", {hs_mode, fs_fallback}, 2);
    endtask

    // R9: timeout leads to full-speed fallback
    task automatic t_timeout();
        do_reset();
        rx_cmd(2'b00);
        while (!reg_req) tick();
        reg_ack = 1'b1; tick(); reg_ack = 1'b0;
        tx_ack = 1'b1; tick(); tx_ack = 1'b0;
        while (!tx_stop) tick();
        tick();
        rx_cmd(2'b10); rx_cmd(2'b01);
        repeat (146) tick();
        check(!fs_fallback && !hs_mode, "R9 no fallback early", {hs_mode, fs_fallback}, 0);
        for (int i = 0; i < 100 && !fs_fallback; i++) tick();
        check(fs_fallback && !hs_mode, "R9 fallback after timeout", {hs_mode, fs_fallback}, 1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        t_reset_state();
        t_se0_qualify();
        t_reg_write();
        t_chirp();
        t_detect_hs();
        t_reset_state();
        t_timeout();
        summary();
        $finish;
    end
endmodule